// File: doc/BRIEF.md
# Sync Pulse Rate Meter

The block measures how many video sync pulses arrive within a fixed gate window timed by the system clock. Two sync inputs reach it, a horizontal sync and a composite sync. A select bit picks which of them is counted. Each input passes through a synchronizer, and the meter counts the rising edges of the chosen one. The window lasts 2^GATE_LOG2 clock cycles. At the end of each window the count, saturated at its maximum, is copied into a latch and a new window begins at once.

Software sees a single byte-wide register. The low CNT_W bits hold the latched count and are read-only. The next bit is the source select, which software can read and write. The bits above it read as zero. A separate enable input switches the meter on. While the enable is low, the window timer and the running count stay cleared and the latch keeps its last result.

Top module: `sync_rate_meter`

## Requirements
- R1: The gate window lasts 2^GATE_LOG2 clock cycles (default 13, so 8192). The first window starts in the first cycle with the enable high. In the last cycle of each window, the running count is copied to reg_rdata[4:0], and the latched value changes in no other cycle.
- R2: The running count is the number of rising edges of the selected input. Each input passes through a two-flop synchronizer, so a pulse counts once however long it stays high.
- R3: When more than 31 edges arrive in one window, the latched value is 31 (0x1F).
- R4: reg_rdata[5] selects the source: 0 counts hsync_in and 1 counts csync_in. The input that is not selected has no effect. A change of the select applies from the next cycle and does not restart the window.
- R5: The select bit is written from reg_wdata[5] in any cycle with reg_wr high. It reads back on reg_rdata[5] and is 0 after reset.
- R6: reg_rdata[7:6] always read 0. A write has no effect on bits 7:6 or on bits 4:0.
- R7: While enable is low, the timer and the running count are held at zero. Pulses seen while the meter is disabled do not appear in any later result.
- R8: While enable is low, the latched count keeps its value.
- R9: When an edge falls in the last cycle of a window, the latch takes the count without that edge, and the next window starts with a count of 1.
- R10: After reset, reg_rdata is 0x00.
- R11: reg_rdata is a combinational function of the latch and the select bit, with no read delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that times the gate window |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Turns the meter on when high |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| csync_in | input | 1 | Composite sync, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data; only bit 5 is used |
| reg_rdata | output | 8 | Register read data {2'b00, select, count} |

## Verification
The bench places a burst of short pulses across a window boundary, so that one edge falls in the capture cycle. A design that counted that edge twice or dropped it would drift from the reference model by one in either the closing window or the next one. It sends 40 pulses in one window to catch a count that wraps to 8 instead of stopping at 31. It writes 0xFF to show that bits 7:6 and the count do not change. It also sends pulses on the input that is not selected. Finally, it drops the enable in the middle of a window and sends pulses while disabled. A latch that cleared would show up at that point, and so would a window that kept counting while disabled.

// File: rtl/srm_pkg.sv
package srm_pkg;
    localparam int REG_W   = 8;
    localparam int NUM_SRC = 2;

    typedef enum logic {
        SRC_HSYNC = 1'b0,
        SRC_CSYNC = 1'b1
    } src_sel_e;
endpackage

// File: rtl/srm_edge_sync.sv
module srm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_in};
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.chain[STAGES-1] & ~st_q.prev;
endmodule

// File: rtl/srm_gate_timer.sv
module srm_gate_timer #(
    parameter int GATE_LOG2 = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic capture_o
);
    localparam logic [GATE_LOG2-1:0] LAST_TICK = '1;

    typedef struct packed {
        logic [GATE_LOG2-1:0] ticks;
    } tmr_st_t;

    tmr_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!enable) st_d.ticks = '0;
        else         st_d.ticks = st_q.ticks + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign capture_o = enable && (st_q.ticks == LAST_TICK);
endmodule

// File: rtl/srm_window_counter.sv
module srm_window_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             capture,
    input  logic             pulse,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] latch_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] held;
    } win_st_t;

    win_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.cnt = '0;
        end else if (capture) begin
            st_d.held = st_q.cnt;
            st_d.cnt  = pulse ? CNT_ONE : '0;
        end else if (pulse && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;
    assign latch_o = st_q.held;
endmodule

// File: rtl/sync_rate_meter.sv
module sync_rate_meter
    import srm_pkg::*;
#(
    parameter int GATE_LOG2   = 13,
    parameter int CNT_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             hsync_in,
    input  logic             csync_in,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata
);
    localparam int SEL_BIT = CNT_W;
    localparam int PAD_W   = REG_W - CNT_W - 1;

    typedef struct packed {
        src_sel_e sel;
    } ctl_st_t;

    ctl_st_t ctl_q, ctl_d;

    logic [NUM_SRC-1:0] raw_src;
    logic [NUM_SRC-1:0] src_rise;
    logic               pulse;
    logic               capture;
    logic [CNT_W-1:0]   cnt_now;
    logic [CNT_W-1:0]   latch_val;
    logic               wdata_unused;

    assign wdata_unused = ^{reg_wdata[REG_W-1:SEL_BIT+1], reg_wdata[SEL_BIT-1:0]};

    always_comb begin
        ctl_d = ctl_q;
        if (reg_wr) ctl_d.sel = src_sel_e'(reg_wdata[SEL_BIT]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{sel: SRC_HSYNC};
        else        ctl_q <= ctl_d;
    end

    assign raw_src[SRC_HSYNC] = hsync_in;
    assign raw_src[SRC_CSYNC] = csync_in;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        srm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (raw_src[g]),
            .rise_o   (src_rise[g])
        );
    end

    assign pulse = src_rise[ctl_q.sel];

    srm_gate_timer #(.GATE_LOG2(GATE_LOG2)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .capture_o (capture)
    );

    srm_window_counter #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .capture (capture),
        .pulse   (pulse),
        .count_o (cnt_now),
        .latch_o (latch_val)
    );

    assign reg_rdata = {{PAD_W{1'b0}}, ctl_q.sel, latch_val};
endmodule

// File: rtl/srm_checker.sv
module srm_checker #(
    parameter int CNT_W = 5,
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             reg_wr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             capture,
    input logic             pulse,
    input logic [CNT_W-1:0] cnt
);
    // R1
    latch_capture_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(reg_rdata[CNT_W-1:0]));

    // R1
    window_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !pulse) |=> (cnt == '0));

    // R3
    count_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !capture && (cnt == '1)) |=> (cnt == '1));

    // R5
    select_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata[CNT_W] == $past(reg_wdata[CNT_W])));

    // R5
    select_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(reg_rdata[CNT_W]));

    // R7
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt == '0));

    // R8
    idle_latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(reg_rdata[CNT_W-1:0]));

    // R9
    capture_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && pulse) |=> (cnt == CNT_W'(1)));
endmodule

bind sync_rate_meter srm_checker #(.CNT_W(CNT_W), .REG_W(srm_pkg::REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .capture   (capture),
    .pulse     (pulse),
    .cnt       (cnt_now)
);

// File: tb/sync_rate_meter_test.sv
module sync_rate_meter_test;
    localparam int CLK_PERIOD = 10;
    localparam int GATE       = 1 << 13;
    localparam int CMAX       = 31;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       hsync_in = 1'b0;
    logic       csync_in = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    int en_cyc = 0;
    bit done = 1'b0;

    // reference model state
    int m_tmr = 0;
    int m_cnt = 0;
    int m_latch = 0;
    bit m_sel = 1'b0;
    bit hq[$];
    bit cq[$];

    sync_rate_meter uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .hsync_in  (hsync_in),
        .csync_in  (csync_in),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit he, ce, ev;
        if (!rst_n) begin
            m_tmr = 0; m_cnt = 0; m_latch = 0; m_sel = 1'b0;
            hq = '{1'b0, 1'b0, 1'b0};
            cq = '{1'b0, 1'b0, 1'b0};
            en_cyc = 0;
        end else begin
            he = hq[1] && !hq[2];
            ce = cq[1] && !cq[2];
            ev = m_sel ? ce : he;
            if (!enable) begin
                m_tmr = 0;
                m_cnt = 0;
                en_cyc = 0;
            end else begin
                en_cyc++;
                if (m_tmr == GATE - 1) begin
                    m_latch = m_cnt;
                    m_cnt = ev ? 1 : 0;
                    m_tmr = 0;
                end else begin
                    m_tmr++;
                    if (ev && m_cnt < CMAX) m_cnt++;
                end
            end
            if (reg_wr) m_sel = reg_wdata[5];
            hq.push_front(hsync_in); void'(hq.pop_back());
            cq.push_front(csync_in); void'(cq.pop_back());
        end
    end

    // cycle-by-cycle comparison against the model (R2 R9 R11)
    always @(negedge clk) begin
        logic [7:0] exp_rd;
        if (rst_n && !done) begin
            exp_rd = {2'b00, m_sel, 5'(m_latch)};
            chk(reg_rdata === exp_rd, "R2 R9 R11 per-cycle model", int'(reg_rdata), int'(exp_rd));
        end
    end

    task automatic pulses(input bit use_cs, input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (use_cs) csync_in = 1'b1; else hsync_in = 1'b1;
            repeat (hi) @(negedge clk);
            if (use_cs) csync_in = 1'b0; else hsync_in = 1'b0;
            repeat (lo - 1) @(negedge clk);
        end
    endtask

    task automatic reg_write(input logic [7:0] val);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = 8'h00;
    endtask

    task automatic wait_after_capture();
        @(negedge clk);
        while ((en_cyc % GATE) != 3) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [4:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset value, R5 select reset to hsync
        chk(reg_rdata == 8'h00, "R10 reset value", int'(reg_rdata), 0);
        chk(reg_rdata[5] == 1'b0, "R5 select after reset", int'(reg_rdata[5]), 0);

        // R1 R2: ten hsync pulses in the first window
        enable = 1'b1;
        pulses(1'b0, 10, 2, 2);
        pulses(1'b1, 6, 2, 2); // R4 unselected source ignored
        chk(reg_rdata[4:0] == 5'd0, "R1 latch unchanged mid-window", int'(reg_rdata[4:0]), 0);
        wait_after_capture();
        chk(reg_rdata[4:0] == 5'd10, "R1 R2 count of first window", int'(reg_rdata[4:0]), 10);

        // R3 saturation
        pulses(1'b0, 40, 2, 2);
        wait_after_capture();
        chk(reg_rdata[4:0] == 5'd31, "R3 saturated count", int'(reg_rdata[4:0]), 31);

        // R5 R6 write 0xFF: select set, upper bits and count untouched
        reg_write(8'hFF);
        chk(reg_rdata[5] == 1'b1, "R5 select written", int'(reg_rdata[5]), 1);
        chk(reg_rdata[7:6] == 2'b00, "R6 upper bits read zero", int'(reg_rdata[7:6]), 0);
        chk(reg_rdata[4:0] == 5'd31, "R6 count unaffected by write", int'(reg_rdata[4:0]), 31);

        // R4 composite source counted, hsync ignored
        pulses(1'b0, 5, 2, 2);
        pulses(1'b1, 7, 2, 2);
        wait_after_capture();
        chk(reg_rdata == 8'h27, "R4 composite source count", int'(reg_rdata), 8'h27);

        // R4 switch back mid-window; R9 edges straddling the capture cycle
        reg_write(8'h00);
        chk(reg_rdata[5] == 1'b0, "R5 select cleared", int'(reg_rdata[5]), 0);
        @(negedge clk);
        while ((en_cyc % GATE) != GATE - 60) @(negedge clk);
        pulses(1'b0, 40, 1, 3);
        wait_after_capture();

        // R7 R8 disable mid-window
        repeat (100) @(negedge clk);
        pulses(1'b0, 4, 2, 2);
        held = reg_rdata[4:0];
        enable = 1'b0;
        pulses(1'b0, 6, 2, 2);
        repeat (300) @(negedge clk);
        chk(reg_rdata[4:0] == held, "R8 latch held while disabled", int'(reg_rdata[4:0]), int'(held));
        enable = 1'b1;
        pulses(1'b0, 3, 2, 2);
        wait_after_capture();
        chk(reg_rdata[4:0] == 5'd3, "R7 fresh window after enable", int'(reg_rdata[4:0]), 3);

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule